// File: doc/BRIEF.md
# MII Receive Deframer

This block sits behind a nibble-wide media-independent receive interface and turns each received frame into a byte stream. It samples the four data lines, the data-valid strobe and the error strobe on the receive clock. It finds the start-of-frame flag, pairs the nibbles that follow into bytes, and hands the bytes on with markers for the first and last byte. Synchronisation needs no more than a single preamble nibble followed by the delimiter nibble, so a frame whose preamble was shortened upstream is still received.

When data-valid falls, the block issues a one-cycle status word alongside the last byte. The status reports a CRC-32 failure, a receive error seen at any point in the frame, a byte count outside the legal length window, and a frame that ended on half a byte. The last byte is marked as it leaves, without any lookahead on the wire, because the block holds one assembled byte back. A frame whose preamble breaks the pattern is dropped without output until data-valid falls.

Top module: `mii_rx_deframer`

## Requirements
- R1: After reset, out_valid, out_first, out_last and stat_valid are all low, and they stay low while rx_dv is low.
- R2: A frame is accepted when rx_dv rises with rxd = 0x5 and the delimiter nibble 0xD follows after one or more 0x5 nibbles. One 0x5 nibble before 0xD is enough.
- R3: A frame whose first nibble under rx_dv is not 0x5, or whose preamble holds any nibble other than 0x5 before the 0xD, produces no byte and no status. The next frame is received normally.
- R4: rxd[0] is the least significant bit of a nibble. The first nibble after the delimiter is bits 3:0 of a byte and the next nibble is bits 7:4.
- R5: Each accepted frame with at least one byte emits its bytes in order with out_valid high. out_first is high on the first byte only and out_last on the final byte only.
- R6: When rx_dv falls on an accepted frame, stat_valid pulses for one cycle in the same cycle as the out_last byte. stat_bytes gives the number of complete bytes, saturating at MAX_LEN+1.
- R7: stat_crc_bad is low exactly when the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) run over every byte, including the four trailing check bytes, leaves the residue 0xC704DD7B (0xDEBB20E3 in reflected register form).
- R8: stat_rx_err is high when rx_er was sampled high in any cycle while rx_dv was high for the frame, preamble included.
- R9: stat_len_bad is high when the byte count is below MIN_LEN (64) or above MAX_LEN (1518).
- R10: When rx_dv falls after an odd number of nibbles past the delimiter, stat_dribble is high and the partial byte is neither output nor counted nor fed to the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 4 | Receive data nibble, bit 0 least significant |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| out_valid | output | 1 | Byte valid |
| out_data | output | 8 | Received byte |
| out_first | output | 1 | First byte of the frame |
| out_last | output | 1 | Final byte of the frame |
| stat_valid | output | 1 | End-of-frame status strobe |
| stat_crc_bad | output | 1 | CRC residue mismatch |
| stat_rx_err | output | 1 | Receive error seen in frame |
| stat_len_bad | output | 1 | Byte count outside MIN_LEN..MAX_LEN |
| stat_dribble | output | 1 | Frame ended on half a byte |
| stat_bytes | output | LEN_W | Complete byte count, saturating |

## Verification
On every cycle the assertions check how the markers are framed. A first marker must not appear inside an open frame, and a middle byte must not appear outside one. The last marker always coincides with the status strobe, the status is followed by a quiet cycle, and the reported count equals the bytes actually delivered. A length verdict reported as good must also lie inside the window. Only the bench scenarios can show the things that depend on stimulus content: the nibble order within a byte, the CRC verdict on good and corrupted frames, the error strobe in mid-frame, dribble handling, the length boundaries 63, 1518 and 1519, and the silent drop and recovery after a malformed preamble.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_DROP = 2'd3
  } rx_state_t;

  localparam logic [3:0]  NIB_PRE        = 4'h5;
  localparam logic [3:0]  NIB_SFD        = 4'hD;
  localparam logic [31:0] CRC_PRESET     = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB8_8320;
  // bit-reversed form of the residue 0xC704DD7B, as seen in a shift-right register
  localparam logic [31:0] CRC_GOOD_REFL  = 32'hDEBB_20E3;
endpackage

// File: rtl/mii_rx_rstsync.sv
module mii_rx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mii_rx_inreg.sv
module mii_rx_inreg #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] d_in,
  input  logic             dv_in,
  input  logic             er_in,
  output logic [NIB_W-1:0] d_q,
  output logic             dv_q,
  output logic             er_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= '0;
      dv_q <= 1'b0;
      er_q <= 1'b0;
    end else begin
      d_q  <= d_in;
      dv_q <= dv_in;
      er_q <= er_in;
    end
  end
endmodule

// File: rtl/mii_rx_crc32.sv
module mii_rx_crc32
  import mii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] data,
  output logic              good
);
  logic [31:0] crc_q;
  logic [31:0] crc_step;
  logic [31:0] crc_d;

  always_comb begin
    crc_step = crc_q;
    for (int i = 0; i < BYTE_W; i++) begin
      if (crc_step[0] ^ data[i]) crc_step = (crc_step >> 1) ^ CRC_POLY_REFL;
      else                       crc_step = crc_step >> 1;
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_PRESET;
    else if (en) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end

  assign good = (crc_q == CRC_GOOD_REFL);
endmodule

// File: rtl/mii_rx_lenchk.sv
module mii_rx_lenchk #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [LEN_W-1:0] cnt,
  output logic             out_of_range
);
  localparam logic [LEN_W-1:0] SAT = LEN_W'(MAX_LEN + 1);
  localparam logic [LEN_W-1:0] LO  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI  = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = '0;
    else if (en && cnt_q != SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt          = cnt_q;
  assign out_of_range = (cnt_q < LO) || (cnt_q > HI);
endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
  import mii_rx_pkg::*;
#(
  parameter  int MIN_LEN = 64,
  parameter  int MAX_LEN = 1518,
  localparam int NIB_W   = 4,
  localparam int BYTE_W  = 2 * NIB_W,
  localparam int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  input  logic              rx_er,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              stat_valid,
  output logic              stat_crc_bad,
  output logic              stat_rx_err,
  output logic              stat_len_bad,
  output logic              stat_dribble,
  output logic [LEN_W-1:0]  stat_bytes
);
  logic             srst_n;
  logic [NIB_W-1:0] d_q;
  logic             dv_q;
  logic             er_q;

  mii_rx_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mii_rx_inreg #(.NIB_W(NIB_W)) u_in (
    .clk(clk), .rst_n(srst_n), .d_in(rxd), .dv_in(rx_dv), .er_in(rx_er),
    .d_q(d_q), .dv_q(dv_q), .er_q(er_q)
  );

  rx_state_t         state_q, state_d;
  logic [NIB_W-1:0]  lo_q, lo_d;
  logic              half_q, half_d;
  logic [BYTE_W-1:0] pend_q, pend_d;
  logic              have_q, have_d;
  logic              pfirst_q, pfirst_d;
  logic              eracc_q, eracc_d;

  logic              ov_d, of_d, ol_d, sv_d, scrc_d, serr_d, slen_d, sdrb_d;
  logic [BYTE_W-1:0] od_d;
  logic [LEN_W-1:0]  sbytes_d;

  logic              crc_clr, crc_en, crc_good;
  logic              len_clr, len_en, len_bad;
  logic [LEN_W-1:0]  len_cnt;
  logic [BYTE_W-1:0] byte_now;

  assign byte_now = {d_q, lo_q};

  mii_rx_crc32 #(.BYTE_W(BYTE_W)) u_crc (
    .clk(clk), .rst_n(srst_n), .clr(crc_clr), .en(crc_en),
    .data(byte_now), .good(crc_good)
  );

  mii_rx_lenchk #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(srst_n), .clr(len_clr), .en(len_en),
    .cnt(len_cnt), .out_of_range(len_bad)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    lo_d     = lo_q;
    half_d   = half_q;
    pend_d   = pend_q;
    have_d   = have_q;
    pfirst_d = pfirst_q;
    eracc_d  = eracc_q;
    ov_d     = 1'b0;
    od_d     = pend_q;
    of_d     = 1'b0;
    ol_d     = 1'b0;
    sv_d     = 1'b0;
    scrc_d   = 1'b0;
    serr_d   = 1'b0;
    slen_d   = 1'b0;
    sdrb_d   = 1'b0;
    sbytes_d = '0;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    len_clr  = 1'b0;
    len_en   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (dv_q) begin
          eracc_d = er_q;
          half_d  = 1'b0;
          have_d  = 1'b0;
          crc_clr = 1'b1;
          len_clr = 1'b1;
          state_d = (d_q == NIB_PRE) ? ST_PRE : ST_DROP;
        end
      end
      ST_PRE: begin
        if (!dv_q) begin
          state_d = ST_IDLE;
        end else begin
          eracc_d = eracc_q | er_q;
          if (d_q == NIB_SFD)      state_d = ST_DATA;
          else if (d_q != NIB_PRE) state_d = ST_DROP;
        end
      end
      ST_DATA: begin
        if (dv_q) begin
          eracc_d = eracc_q | er_q;
          if (!half_q) begin
            lo_d   = d_q;
            half_d = 1'b1;
          end else begin
            half_d = 1'b0;
            crc_en = 1'b1;
            len_en = 1'b1;
            if (have_q) begin
              ov_d = 1'b1;
              of_d = pfirst_q;
            end
            pend_d   = byte_now;
            pfirst_d = !have_q;
            have_d   = 1'b1;
          end
        end else begin
          if (have_q) begin
            ov_d = 1'b1;
            of_d = pfirst_q;
            ol_d = 1'b1;
          end
          sv_d     = 1'b1;
          scrc_d   = !crc_good;
          serr_d   = eracc_q;
          slen_d   = len_bad;
          sdrb_d   = half_q;
          sbytes_d = len_cnt;
          have_d   = 1'b0;
          half_d   = 1'b0;
          state_d  = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (!dv_q) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q      <= ST_IDLE;
      lo_q         <= '0;
      half_q       <= 1'b0;
      pend_q       <= '0;
      have_q       <= 1'b0;
      pfirst_q     <= 1'b0;
      eracc_q      <= 1'b0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_first    <= 1'b0;
      out_last     <= 1'b0;
      stat_valid   <= 1'b0;
      stat_crc_bad <= 1'b0;
      stat_rx_err  <= 1'b0;
      stat_len_bad <= 1'b0;
      stat_dribble <= 1'b0;
      stat_bytes   <= '0;
    end else begin
      state_q      <= state_d;
      lo_q         <= lo_d;
      half_q       <= half_d;
      pend_q       <= pend_d;
      have_q       <= have_d;
      pfirst_q     <= pfirst_d;
      eracc_q      <= eracc_d;
      out_valid    <= ov_d;
      out_data     <= od_d;
      out_first    <= of_d;
      out_last     <= ol_d;
      stat_valid   <= sv_d;
      stat_crc_bad <= scrc_d;
      stat_rx_err  <= serr_d;
      stat_len_bad <= slen_d;
      stat_dribble <= sdrb_d;
      stat_bytes   <= sbytes_d;
    end
  end
endmodule

// File: rtl/mii_rx_deframer_chk.sv
module mii_rx_deframer_chk #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_first,
  input logic             out_last,
  input logic             stat_valid,
  input logic             stat_len_bad,
  input logic [LEN_W-1:0] stat_bytes
);
  logic        in_frame_q;
  logic [15:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      seen_q     <= '0;
    end else begin
      if (stat_valid)     in_frame_q <= 1'b0;
      else if (out_first) in_frame_q <= 1'b1;
      if (stat_valid)     seen_q <= '0;
      else if (out_valid) seen_q <= seen_q + 16'd1;
    end
  end

  p_first_is_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  p_first_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> !in_frame_q);
  p_mid_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> in_frame_q);
  p_last_with_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (stat_valid && out_valid));
  p_status_then_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> (!stat_valid && !out_valid));
  p_count_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (int'(stat_bytes) <= MAX_LEN)) |->
      (int'(stat_bytes) == int'(seen_q) + int'(out_valid)));
  p_len_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_len_bad) |->
      (int'(stat_bytes) >= MIN_LEN && int'(stat_bytes) <= MAX_LEN));
endmodule

bind mii_rx_deframer mii_rx_deframer_chk #(
  .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_first(out_first),
  .out_last(out_last), .stat_valid(stat_valid), .stat_len_bad(stat_len_bad),
  .stat_bytes(stat_bytes)
);

// File: tb/mii_rx_deframer_test.sv
module mii_rx_deframer_test;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       rxd;
  logic             rx_dv, rx_er;
  logic             out_valid, out_first, out_last;
  logic [7:0]       out_data;
  logic             stat_valid, stat_crc_bad, stat_rx_err, stat_len_bad, stat_dribble;
  logic [LEN_W-1:0] stat_bytes;

  always #2.5 clk = ~clk;

  mii_rx_deframer uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .stat_valid(stat_valid), .stat_crc_bad(stat_crc_bad),
    .stat_rx_err(stat_rx_err), .stat_len_bad(stat_len_bad),
    .stat_dribble(stat_dribble), .stat_bytes(stat_bytes)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] fr [0:1599];
  int         fr_n;
  logic [3:0] pre_seq [0:15];
  int         pre_len;

  logic [7:0] got [0:1599];
  int ng, firsts, lasts, stats, first_idx, last_idx;
  bit last_with_stat;
  bit s_crc, s_err, s_len, s_drb;
  int s_bytes;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (ng < 1600) got[ng] = out_data;
        if (out_first) begin firsts++; first_idx = ng; end
        if (out_last)  begin lasts++;  last_idx  = ng; last_with_stat = stat_valid; end
        ng++;
      end
      if (stat_valid) begin
        stats++;
        s_crc = stat_crc_bad; s_err = stat_rx_err; s_len = stat_len_bad;
        s_drb = stat_dribble; s_bytes = int'(stat_bytes);
      end
    end
  end

  task automatic build(input int npay, input int seed, input bit good_fcs);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < npay; i++) begin
      fr[i] = 8'((seed * 37 + i * 11 + (i >> 3)) & 8'hFF);
      c = crc_upd(c, fr[i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fr[npay + k] = c[8*k +: 8];
    fr_n = npay + 4;
    if (!good_fcs) fr[npay / 2] = fr[npay / 2] ^ 8'h10;
  endtask

  task automatic set_pre(input int n5);
    for (int i = 0; i < n5; i++) pre_seq[i] = 4'h5;
    pre_seq[n5] = 4'hD;
    pre_len = n5 + 1;
  endtask

  task automatic nib(input logic [3:0] v, input bit er);
    @(posedge clk); #1;
    rx_dv = 1'b1; rxd = v; rx_er = er;
  endtask

  task automatic send(input int er_at, input bit odd);
    int t;
    ng = 0; firsts = 0; lasts = 0; stats = 0; first_idx = -1; last_idx = -1;
    last_with_stat = 1'b0; s_crc = 0; s_err = 0; s_len = 0; s_drb = 0; s_bytes = -1;
    t = 0;
    for (int i = 0; i < pre_len; i++) nib(pre_seq[i], 1'b0);
    for (int i = 0; i < fr_n; i++) begin
      nib(fr[i][3:0], t == er_at); t++;
      nib(fr[i][7:4], t == er_at); t++;
    end
    if (odd) nib(4'hF, 1'b0);
    @(posedge clk); #1;
    rx_dv = 1'b0; rxd = 4'h0; rx_er = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic expect_frame(input string tag, input int nbytes, input bit crc_bad,
                              input bit rxerr, input bit lenbad, input bit drb);
    int mism, first_bad_i;
    chk(stats == 1, "R6", {tag, " status pulses"}, stats, 1);
    chk(firsts == 1 && first_idx == 0, "R5", {tag, " first marker index"}, first_idx, 0);
    chk(lasts == 1 && last_idx == nbytes - 1, "R5", {tag, " last marker index"}, last_idx, nbytes - 1);
    chk(last_with_stat, "R6", {tag, " last with status"}, last_with_stat, 1);
    chk(ng == nbytes, "R6", {tag, " bytes delivered"}, ng, nbytes);
    chk(s_bytes == (nbytes > 1518 ? 1519 : nbytes), "R6", {tag, " stat_bytes"},
        s_bytes, (nbytes > 1518 ? 1519 : nbytes));
    mism = 0; first_bad_i = -1;
    for (int i = 0; i < nbytes && i < ng; i++)
      if (got[i] !== fr[i]) begin mism++; if (first_bad_i < 0) first_bad_i = i; end
    chk(mism == 0, "R4", {tag, " byte content"},
        first_bad_i < 0 ? 0 : got[first_bad_i], first_bad_i < 0 ? 0 : fr[first_bad_i]);
    chk(s_crc == crc_bad, "R7", {tag, " crc flag"}, s_crc, crc_bad);
    chk(s_err == rxerr, "R8", {tag, " rx error flag"}, s_err, rxerr);
    chk(s_len == lenbad, "R9", {tag, " length flag"}, s_len, lenbad);
    chk(s_drb == drb, "R10", {tag, " dribble flag"}, s_drb, drb);
  endtask

  task automatic t_reset;
    chk(!out_valid && !out_first && !out_last && !stat_valid, "R1", "idle after reset",
        {out_valid, out_first, out_last, stat_valid}, 0);
  endtask

  task automatic t_min_preamble;
    build(60, 1, 1'b1); set_pre(1); send(-1, 1'b0);
    expect_frame("R2 one-nibble preamble", 64, 0, 0, 0, 0);
    chk(got[0] == fr[0] && got[1] == fr[1], "R4", "nibble order first bytes", got[0], fr[0]);
  endtask

  task automatic t_long_preamble;
    build(96, 2, 1'b1); set_pre(15); send(-1, 1'b0);
    expect_frame("R2 long preamble", 100, 0, 0, 0, 0);
  endtask

  task automatic t_bad_crc;
    build(80, 3, 1'b0); set_pre(7); send(-1, 1'b0);
    expect_frame("R7 corrupted", 84, 1, 0, 0, 0);
  endtask

  task automatic t_rx_err;
    build(70, 4, 1'b1); set_pre(7); send(41, 1'b0);
    expect_frame("R8 mid-frame error", 74, 0, 1, 0, 0);
  endtask

  task automatic t_lengths;
    build(59, 5, 1'b1); set_pre(3); send(-1, 1'b0);
    expect_frame("R9 63 bytes", 63, 0, 0, 1, 0);
    build(1514, 6, 1'b1); set_pre(3); send(-1, 1'b0);
    expect_frame("R9 1518 bytes", 1518, 0, 0, 0, 0);
    build(1515, 7, 1'b1); set_pre(3); send(-1, 1'b0);
    expect_frame("R9 1519 bytes", 1519, 0, 0, 1, 0);
  endtask

  task automatic t_dribble;
    build(64, 8, 1'b1); set_pre(7); send(-1, 1'b1);
    expect_frame("R10 odd nibble", 68, 0, 0, 0, 1);
  endtask

  task automatic t_bad_preamble;
    build(60, 9, 1'b1);
    pre_seq[0] = 4'hD; pre_len = 1; send(-1, 1'b0);
    chk(ng == 0 && stats == 0, "R3", "sfd without preamble dropped", ng + stats, 0);
    pre_seq[0] = 4'h5; pre_seq[1] = 4'h7; pre_seq[2] = 4'h5; pre_seq[3] = 4'hD;
    pre_len = 4; send(-1, 1'b0);
    chk(ng == 0 && stats == 0, "R3", "broken preamble dropped", ng + stats, 0);
    set_pre(2); send(-1, 1'b0);
    expect_frame("R3 recovery", 64, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rxd = 4'h0; rx_dv = 1'b0; rx_er = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_min_preamble();
    t_long_preamble();
    t_bad_crc();
    t_rx_err();
    t_lengths();
    t_dribble();
    t_bad_preamble();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule